// File: doc/BRIEF.md
# CAM Co-Processor Bring-Up Sequencer

This block sits on the host side of a ternary CAM lookup co-processor and takes it from reset to operating state without software help. While idle it holds the co-processor in reset with the request strobe low. A single-cycle `start` pulse, given once supplies and clocks are good, begins the sequence. The block holds reset for a programmed number of cycles. It then releases reset and raises the ID-configuration line for the device chain. After that it issues a fixed series of write transactions on the 7-bit command bus and the 72-bit request bus.

Each write has two phases of two clock cycles each. In the first phase the strobe is high and the command bus carries the write code and a select word. In the second phase the strobe is low and the request bus carries the data word. The writes are issued in this order:

1. A configuration-register write that enables the handshake outputs.
2. A sweep that clears every data entry.
3. A sweep that sets every mask entry.
4. The optional global mask registers, taken from a parameter table.
5. The four reply width registers.
6. The final configuration-register write.

The block then raises `done` and holds all of its outputs steady until `rst_n` is asserted. Every bus here is a fixed-timing strobe bus toward the co-processor, so there is no back-pressure. All waits are counted by a single down-counter that is reloaded at the start of each phase.

Top module: `cam_init_seq`

## Requirements
- R1: Before `start`, with `rst_n` high, `co_rst_n`, `co_strobe`, `co_cfg`, `busy` and `done` are 0, and `co_cmd` and `co_req` are all zeros.
- R2: From the clock edge that samples `start`, `co_rst_n` and `co_strobe` stay low for exactly RST_CYC cycles, with `busy` high.
- R3: `co_rst_n` then rises, and `co_cfg` is high for exactly CFG_CYC*NUM_DEV cycles before the first strobe. `co_cfg` then stays high through `done`.
- R4: Every write is 2 cycles with `co_strobe`=1, `co_cmd`=7'b0000100 and the select word on `co_req`, followed by 2 cycles with `co_strobe`=0, `co_cmd`=0 and the data word on `co_req`. Every select word carries DEV_ID in bits [33:26].
- R5: The first write selects register address 8'h03 in bits [8:1]. Its data word has only bit 28 set, and that bit equals LAST_DEV.
- R6: The next DEPTH writes carry 2'b01 in bits [25:24] and 2'b11 in bits [23:22]. The entry address is in bits [15:1], counting from 0 to DEPTH-1 in steps of one, and each data word is all zeros.
- R7: The next DEPTH writes are the same as in R6, except that bits [25:24] are 2'b10 and each data word is all ones.
- R8: Next come NUM_GMR writes in slot order. Slot k takes its address (bits [8:1]) from byte k of GMR_ADDR_TBL and its data from word k of GMR_DATA_TBL. When NUM_GMR is 0 there are none.
- R9: Next come four writes to register addresses 8'h04 to 8'h07, in that order. Each carries the matching 72-bit word of RWR_TBL, with word 0 in the least significant position.
- R10: The last write selects address 8'h03. Its data word has bit 31=1, bit 30=1, bit 29=LAST_SRAM and bit 28=LAST_DEV, and all other bits are 0.
- R11: On the cycle after the last data phase, `done` is 1 and `busy` is 0, with `co_rst_n`=1, `co_cfg`=1, strobe low and both buses zero. This state holds until `rst_n` is asserted.
- R12: A `start` pulse while `busy` or `done` is high does not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock of the co-processor interface |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| start | input | 1 | One-cycle pulse: supplies and clocks are good, begin bring-up |
| co_rst_n | output | 1 | Active-low reset to the co-processor |
| co_strobe | output | 1 | Request strobe, high during select phases |
| co_cfg | output | 1 | ID-configuration line into the device chain |
| co_cmd | output | 7 | Command bus |
| co_req | output | 72 | Request bus (select word or write data) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The bound checker enforces several rules on every cycle:
- The strobe never rises while the co-processor is held in reset.
- Every strobe cycle carries the write code and the device ID.
- The configuration line is high whenever a strobe is issued.
- Strobe highs and lows come in pairs.
- `busy` and `done` are exclusive, and `done` is sticky.
- A start pulse during a run cannot return the block to idle.

Other properties can only be shown by the bench's cycle-accurate reference model, compared on every clock:
- the exact lengths of the reset and configuration windows;
- the order of the writes;
- the address sweep of both arrays and their fill patterns;
- the table-driven register contents;
- the two configuration-register encodings.

// File: rtl/cam_init_pkg.sv
package cam_init_pkg;
  localparam int CMD_W  = 7;
  localparam int REQ_W  = 72;
  localparam int SLOT_N = 16;

  localparam logic [CMD_W-1:0] CMD_WRITE = 7'b0000100;
  localparam logic [7:0] ADDR_SYSCFG   = 8'h03;
  localparam logic [7:0] ADDR_RWR_BASE = 8'h04;
  localparam logic [1:0] ACC_DATA      = 2'b01;
  localparam logic [1:0] ACC_MASK      = 2'b10;
  localparam logic [1:0] GMSEL_NONE    = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_CFG, ST_SEL, ST_DAT, ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    WK_CFG_HS, WK_DATA, WK_MASK, WK_GMR, WK_RWR, WK_CFG_FIN
  } wr_kind_e;
endpackage

// File: rtl/cam_init_fsm.sv
module cam_init_fsm
  import cam_init_pkg::*;
#(
  parameter int DEPTH     = 32768,
  parameter int NUM_GMR   = 2,
  parameter int RST_CYC   = 32,
  parameter int CFG_TOTAL = 16,
  parameter int IDX_W     = 15,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output seq_state_e       state,
  output wr_kind_e         kind,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] IDX_ARR_LAST = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] IDX_GMR_LAST = IDX_W'(NUM_GMR - 1);
  localparam logic [IDX_W-1:0] IDX_RWR_LAST = IDX_W'(3);

  logic [CNT_W-1:0] cnt;
  wr_kind_e         nkind;
  logic [IDX_W-1:0] nidx;
  logic             last_write;

  always_comb begin
    nkind      = kind;
    nidx       = idx + 1'b1;
    last_write = 1'b0;
    case (kind)
      WK_CFG_HS: begin nkind = WK_DATA; nidx = '0; end
      WK_DATA: if (idx == IDX_ARR_LAST) begin nkind = WK_MASK; nidx = '0; end
      WK_MASK: if (idx == IDX_ARR_LAST) begin
        nkind = (NUM_GMR > 0) ? WK_GMR : WK_RWR;
        nidx  = '0;
      end
      WK_GMR: if (idx == IDX_GMR_LAST) begin nkind = WK_RWR; nidx = '0; end
      WK_RWR: if (idx == IDX_RWR_LAST) begin nkind = WK_CFG_FIN; nidx = '0; end
      default: begin last_write = 1'b1; nidx = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      kind  <= WK_CFG_HS;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RST;
          cnt   <= CNT_W'(RST_CYC - 1);
        end
        ST_RST: if (cnt == '0) begin
          state <= ST_CFG;
          cnt   <= CNT_W'(CFG_TOTAL - 1);
        end else cnt <= cnt - 1'b1;
        ST_CFG: if (cnt == '0) begin
          state <= ST_SEL;
          cnt   <= CNT_W'(1);
          kind  <= WK_CFG_HS;
          idx   <= '0;
        end else cnt <= cnt - 1'b1;
        ST_SEL: if (cnt == '0) begin
          state <= ST_DAT;
          cnt   <= CNT_W'(1);
        end else cnt <= cnt - 1'b1;
        ST_DAT: if (cnt == '0) begin
          if (last_write) state <= ST_DONE;
          else begin
            state <= ST_SEL;
            cnt   <= CNT_W'(1);
            kind  <= nkind;
            idx   <= nidx;
          end
        end else cnt <= cnt - 1'b1;
        default: state <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/cam_init_word.sv
module cam_init_word
  import cam_init_pkg::*;
#(
  parameter int                     IDX_W        = 15,
  parameter logic [7:0]             DEV_ID       = 8'h00,
  parameter bit                     LAST_DEV     = 1'b1,
  parameter bit                     LAST_SRAM    = 1'b1,
  parameter logic [SLOT_N*8-1:0]    GMR_ADDR_TBL = '0,
  parameter logic [SLOT_N*REQ_W-1:0] GMR_DATA_TBL = '0,
  parameter logic [4*REQ_W-1:0]     RWR_TBL      = '0
) (
  input  seq_state_e       state,
  input  wr_kind_e         kind,
  input  logic [IDX_W-1:0] idx,
  output logic             co_rst_n,
  output logic             co_strobe,
  output logic             co_cfg,
  output logic [CMD_W-1:0] co_cmd,
  output logic [REQ_W-1:0] co_req
);
  logic [3:0]       slot;
  logic [1:0]       rsel;
  logic [REQ_W-1:0] sel_w;
  logic [REQ_W-1:0] dat_w;

  assign slot = idx[3:0];
  assign rsel = idx[1:0];

  always_comb begin
    sel_w        = '0;
    sel_w[33:26] = DEV_ID;
    dat_w        = '0;
    case (kind)
      WK_CFG_HS: begin
        sel_w[8:1] = ADDR_SYSCFG;
        dat_w[28]  = LAST_DEV;
      end
      WK_DATA: begin
        sel_w[25:24] = ACC_DATA;
        sel_w[23:22] = GMSEL_NONE;
        sel_w[15:1]  = 15'(idx);
      end
      WK_MASK: begin
        sel_w[25:24] = ACC_MASK;
        sel_w[23:22] = GMSEL_NONE;
        sel_w[15:1]  = 15'(idx);
        dat_w        = '1;
      end
      WK_GMR: begin
        sel_w[8:1] = GMR_ADDR_TBL[slot*8 +: 8];
        dat_w      = GMR_DATA_TBL[slot*REQ_W +: REQ_W];
      end
      WK_RWR: begin
        sel_w[8:1] = ADDR_RWR_BASE + {6'b0, rsel};
        dat_w      = RWR_TBL[rsel*REQ_W +: REQ_W];
      end
      default: begin
        sel_w[8:1] = ADDR_SYSCFG;
        dat_w[31]  = 1'b1;
        dat_w[30]  = 1'b1;
        dat_w[29]  = LAST_SRAM;
        dat_w[28]  = LAST_DEV;
      end
    endcase
  end

  assign co_rst_n  = (state != ST_IDLE) && (state != ST_RST);
  assign co_cfg    = (state == ST_CFG) || (state == ST_SEL) ||
                     (state == ST_DAT) || (state == ST_DONE);
  assign co_strobe = (state == ST_SEL);
  assign co_cmd    = (state == ST_SEL) ? CMD_WRITE : '0;
  assign co_req    = (state == ST_SEL) ? sel_w :
                     (state == ST_DAT) ? dat_w : '0;
endmodule

// File: rtl/cam_init_seq.sv
module cam_init_seq
  import cam_init_pkg::*;
#(
  parameter int                      DEPTH        = 32768,
  parameter int                      NUM_GMR      = 2,
  parameter int                      NUM_DEV      = 1,
  parameter int                      RST_CYC      = 32,
  parameter int                      CFG_CYC      = 16,
  parameter logic [7:0]              DEV_ID       = 8'h00,
  parameter bit                      LAST_DEV     = 1'b1,
  parameter bit                      LAST_SRAM    = 1'b1,
  parameter logic [SLOT_N*8-1:0]     GMR_ADDR_TBL = {112'h0, 8'h30, 8'h10},
  parameter logic [SLOT_N*REQ_W-1:0] GMR_DATA_TBL = {1008'h0,
                                                     72'h00_0000_FFFF_FFFF_FFFF,
                                                     72'hFF_FFFF_FFFF_0000_0000},
  parameter logic [4*REQ_W-1:0]      RWR_TBL      = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             co_rst_n,
  output logic             co_strobe,
  output logic             co_cfg,
  output logic [CMD_W-1:0] co_cmd,
  output logic [REQ_W-1:0] co_req,
  output logic             busy,
  output logic             done
);
  localparam int CFG_TOTAL = CFG_CYC * NUM_DEV;
  localparam int WAIT_MAX  = (RST_CYC > CFG_TOTAL) ? RST_CYC : CFG_TOTAL;
  localparam int CNT_W     = $clog2(WAIT_MAX + 1);
  localparam int IDX_W     = $clog2((DEPTH > SLOT_N) ? DEPTH : SLOT_N);

  seq_state_e       state;
  wr_kind_e         kind;
  logic [IDX_W-1:0] idx;

  cam_init_fsm #(
    .DEPTH(DEPTH), .NUM_GMR(NUM_GMR), .RST_CYC(RST_CYC),
    .CFG_TOTAL(CFG_TOTAL), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .state(state), .kind(kind), .idx(idx)
  );

  cam_init_word #(
    .IDX_W(IDX_W), .DEV_ID(DEV_ID), .LAST_DEV(LAST_DEV), .LAST_SRAM(LAST_SRAM),
    .GMR_ADDR_TBL(GMR_ADDR_TBL), .GMR_DATA_TBL(GMR_DATA_TBL), .RWR_TBL(RWR_TBL)
  ) u_word (
    .state(state), .kind(kind), .idx(idx),
    .co_rst_n(co_rst_n), .co_strobe(co_strobe), .co_cfg(co_cfg),
    .co_cmd(co_cmd), .co_req(co_req)
  );

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/cam_init_seq_chk.sv
module cam_init_seq_chk #(
  parameter logic [7:0] DEV_ID = 8'h00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        co_rst_n,
  input logic        co_strobe,
  input logic        co_cfg,
  input logic [6:0]  co_cmd,
  input logic [71:0] co_req,
  input logic        busy,
  input logic        done
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (!co_rst_n && !co_strobe && !co_cfg));
  assert_no_strobe_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !co_rst_n |-> !co_strobe);
  assert_cfg_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    co_strobe |-> co_cfg);
  assert_strobe_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    co_strobe |-> (co_cmd == 7'b0000100));
  assert_strobe_devid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    co_strobe |-> (co_req[33:26] == DEV_ID));
  assert_strobe_pair_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(co_strobe) |=> co_strobe);
  assert_strobe_pair_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(co_strobe) |=> !co_strobe);
  assert_busy_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !co_strobe));
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind cam_init_seq cam_init_seq_chk #(.DEV_ID(DEV_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .co_rst_n(co_rst_n),
  .co_strobe(co_strobe), .co_cfg(co_cfg), .co_cmd(co_cmd), .co_req(co_req),
  .busy(busy), .done(done)
);

// File: tb/cam_init_seq_bench.sv
module cam_init_seq_bench;
  localparam int          DEPTH     = 8;
  localparam int          NUM_GMR   = 2;
  localparam int          NUM_DEV   = 2;
  localparam int          RST_CYC   = 32;
  localparam int          CFG_CYC   = 16;
  localparam logic [7:0]  DEV       = 8'h05;
  localparam bit          LDEV      = 1'b1;
  localparam bit          LSRAM     = 1'b0;
  localparam logic [127:0]  GADDR = {112'h0, 8'h25, 8'h12};
  localparam logic [1151:0] GDATA = {1008'h0, 72'hA5_0000_1111_2222_3333,
                                     72'h3C_DEAD_BEEF_0F0F_F0F0};
  localparam logic [287:0]  RWRS  = {72'h44_0000_0000_0000_0004,
                                     72'h33_0000_0000_0000_0003,
                                     72'h22_0000_0000_0000_0002,
                                     72'h11_0000_0000_0000_0001};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic co_rst_n, co_strobe, co_cfg, busy, done;
  logic [6:0]  co_cmd;
  logic [71:0] co_req;

  always #10 clk = ~clk;

  cam_init_seq #(
    .DEPTH(DEPTH), .NUM_GMR(NUM_GMR), .NUM_DEV(NUM_DEV), .RST_CYC(RST_CYC),
    .CFG_CYC(CFG_CYC), .DEV_ID(DEV), .LAST_DEV(LDEV), .LAST_SRAM(LSRAM),
    .GMR_ADDR_TBL(GADDR), .GMR_DATA_TBL(GDATA), .RWR_TBL(RWRS)
  ) u_cam_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .co_rst_n(co_rst_n),
    .co_strobe(co_strobe), .co_cfg(co_cfg), .co_cmd(co_cmd), .co_req(co_req),
    .busy(busy), .done(done)
  );

  typedef struct {
    logic rn; logic stb; logic cfg; logic [6:0] cmd; logic [71:0] req;
    logic bsy; logic dn; string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 0;

  function automatic void push(logic rn, logic stb, logic cfg, logic [6:0] cmd,
                               logic [71:0] req, logic bsy, logic dn, string tag);
    exp_t e;
    e.rn = rn; e.stb = stb; e.cfg = cfg; e.cmd = cmd; e.req = req;
    e.bsy = bsy; e.dn = dn; e.tag = tag;
    q.push_back(e);
  endfunction

  function automatic void add_write(logic [71:0] sel, logic [71:0] dat, string tag);
    for (int k = 0; k < 2; k++) push(1, 1, 1, 7'b0000100, sel, 1, 0, tag);
    for (int k = 0; k < 2; k++) push(1, 0, 1, 7'h00, dat, 1, 0, tag);
  endfunction

  function automatic logic [71:0] reg_sel(logic [7:0] a);
    return (72'(DEV) << 26) | (72'(a) << 1);
  endfunction

  function automatic logic [71:0] arr_sel(logic [1:0] acc, int a);
    return (72'(DEV) << 26) | (72'(acc) << 24) | (72'h3 << 22) | (72'(a[14:0]) << 1);
  endfunction

  task automatic check(exp_t e);
    n_chk++;
    if (co_rst_n !== e.rn || co_strobe !== e.stb || co_cfg !== e.cfg ||
        co_cmd !== e.cmd || co_req !== e.req || busy !== e.bsy || done !== e.dn) begin
      n_err++;
      $display("FAIL %s: actual rn=%b stb=%b cfg=%b cmd=%h req=%h busy=%b done=%b expected rn=%b stb=%b cfg=%b cmd=%h req=%h busy=%b done=%b",
               e.tag, co_rst_n, co_strobe, co_cfg, co_cmd, co_req, busy, done,
               e.rn, e.stb, e.cfg, e.cmd, e.req, e.bsy, e.dn);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    exp_t idle_e, done_e;
    idle_e.rn = 0; idle_e.stb = 0; idle_e.cfg = 0; idle_e.cmd = 0; idle_e.req = 0;
    idle_e.bsy = 0; idle_e.dn = 0; idle_e.tag = "R1";
    done_e = idle_e;
    done_e.rn = 1; done_e.cfg = 1; done_e.dn = 1; done_e.tag = "R11";

    // Reference sequence derived from the requirements
    for (int i = 0; i < RST_CYC; i++) push(0, 0, 0, 7'h00, 72'h0, 1, 0, "R2");
    for (int i = 0; i < CFG_CYC * NUM_DEV; i++) push(1, 0, 1, 7'h00, 72'h0, 1, 0, "R3");
    add_write(reg_sel(8'h03), 72'(LDEV) << 28, "R5");
    for (int a = 0; a < DEPTH; a++) add_write(arr_sel(2'b01, a), 72'h0, "R6");
    for (int a = 0; a < DEPTH; a++) add_write(arr_sel(2'b10, a), {72{1'b1}}, "R7");
    for (int g = 0; g < NUM_GMR; g++)
      add_write(reg_sel(GADDR[g*8 +: 8]), GDATA[g*72 +: 72], "R8");
    for (int r = 0; r < 4; r++)
      add_write(reg_sel(8'h04 + 8'(r)), RWRS[r*72 +: 72], "R9");
    add_write(reg_sel(8'h03),
              (72'h1 << 31) | (72'h1 << 30) | (72'(LSRAM) << 29) | (72'(LDEV) << 28),
              "R10");

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(idle_e);   // R1
    end
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      start = (i == 40 || i == 150);   // R12: pulses during the run
      check(q[i]);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start = (i == 1);                // R12: pulse while done
      check(done_e);                   // R11
    end
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual done=%b expected done=1", done);
    report();
  end
endmodule